// File: doc/BRIEF.md
# DRAM Page-Mode Bank Controller

This block sequences one bank of fast-page-mode DRAM. It remembers which row (page) is currently open and, for each incoming access, decides whether the address falls inside that page. A page hit is served with a CAS pulse alone. A page miss closes the row, waits one precharge clock, opens the new row and then runs the CAS pulse. The block also runs a periodic CAS-before-RAS refresh, timed by a prescaled counter. The row/column address multiplexer, bank decoding, arbitration and the memory array sit outside the block. The strobes are reported as logical "asserted" levels, and any inversion needed at the pins is applied outside.

A requester raises `req_i` with a stable address, direction and port width, and holds it until `ack_o` pulses for one clock. `hit_o` tells whether that access was served as a page hit. The range of address bits compared for a hit always reaches the top address bit. Its lowest bit depends on a 3-bit page-size code and on whether the port is 16 or 32 bits wide. Page-hit writes can be stretched by one clock, which delays both CAS edges. The block forces this stretch by itself when page mode is combined with zero wait states and the delayed-write setting is off, and it flags that combination on `cfg_err_o`.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, RAS, CAS and the acknowledge are all low and no page is open, so the first access reports `hit_o`=0.
- R2: On a 32-bit port (`port16_i`=0) the page comparison covers the bits from a lowest bit up to A25. Page-size codes 0 to 7 set that lowest bit to 10, 11, 11, 12, 12, 13, 13 and 14. Bits below the lowest bit never cause a miss, and a change in the lowest bit always does.
- R3: On a 16-bit port (`port16_i`=1) the lowest compared bit is one position lower than on a 32-bit port with the same page-size code.
- R4: A page-hit read with wait count W asserts CAS in the first cycle after the accepting edge and holds it for W+1 cycles. `ack_o` is high for exactly one cycle, W+1 edges after the accepting edge, and `hit_o`=1 in that cycle.
- R5: On a page miss, RAS is low in the first cycle after acceptance (precharge) and high in the second. CAS follows one cycle after RAS rises and is held for W+1 cycles, with the acknowledge W+3 edges after acceptance. The new page is then open, so a later access to it hits.
- R6: When delayed write is on, a page-hit write starts CAS one cycle later and ends it one cycle later than a read, so its acknowledge comes W+2 edges after acceptance. Page-hit reads and page-miss writes keep their normal timing.
- R7: When page mode is on, the wait count is 0 and delayed write is off, `cfg_err_o`=1 and page-hit writes are stretched as in R6. In every other configuration `cfg_err_o`=0.
- R8: When page mode is off, every access is a miss with R5 timing, and RAS is low once the access has been acknowledged.
- R9: With refresh count N and no traffic, refresh cycles start every 16*(N+1) clocks.
- R10: A refresh cycle asserts CAS while RAS is low, then raises RAS with CAS still high for one cycle, then drops both. The page that was open before the refresh is closed, so the next access to it is a miss.
- R11: A refresh that is pending when the sequencer is idle is started before a request waiting at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, held until acknowledged |
| addr_i | input | 26 | Byte address of the access |
| wr_i | input | 1 | 1 = write, 0 = read |
| port16_i | input | 1 | 1 = 16-bit port, 0 = 32-bit port |
| pgsz_i | input | 3 | Page-size code |
| pgmode_i | input | 1 | Page-mode enable |
| dlywr_i | input | 1 | Delayed-write enable for page-hit writes |
| wait_i | input | 4 | Extra CAS cycles (wait count W) |
| rfcnt_i | input | 8 | Refresh count N (period 16*(N+1) clocks) |
| ras_o | output | 1 | Row strobe, asserted high |
| cas_o | output | 1 | Column strobe, asserted high |
| ack_o | output | 1 | One-cycle access-done pulse |
| hit_o | output | 1 | Access was a page hit (valid with ack_o) |
| cfg_err_o | output | 1 | Page mode with zero wait and no delayed write |

## Verification
For the page comparison, the bench sweeps all eight page-size codes on both port widths. At each code it flips the bit just below the expected lowest compared bit and then the lowest bit itself, which pins the mask boundary down to a single position. Access timing is tried with reads and writes, hits and misses, and delayed write both on and off. Comparing the acknowledge latency and the first CAS cycle across these cases separates the normal, stretched and miss paths, and the zero-wait configuration tells forced stretching apart from the explicit setting. Refresh is measured on an idle bank to get the period, observed just after an open page to check the strobe order and the page closure, and raced against a request issued on the cycle the refresh becomes pending.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int ADDR_W = 26;
    localparam int LSB_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_CAS_GO,
        ST_CAS_ON,
        ST_RF_PRE,
        ST_RF_CAS,
        ST_RF_RAS
    } seq_state_t;

    typedef struct packed {
        logic ras;
        logic cas;
        logic ack;
    } strobe_t;

    // Lowest address bit that takes part in the page comparison.
    function automatic logic [LSB_W-1:0] cmp_lsb(input logic [2:0] code, input logic narrow);
        int v;
        v = 10 + (int'(code) + 1) / 2 - (narrow ? 1 : 0);
        return LSB_W'(v);
    endfunction

    // Page mode with zero wait states needs the stretched write.
    function automatic logic cfg_conflict(input logic pgmode, input logic dlywr, input logic wait_zero);
        return pgmode && wait_zero && !dlywr;
    endfunction

endpackage

// File: rtl/dpc_page_match.sv
module dpc_page_match
    import dpc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] open_page_i,
    input  logic [2:0]    code_i,
    input  logic          narrow_i,
    output logic          match_o
);
    logic [LSB_W-1:0] lsb;
    logic [AW-1:0]    mask;
    logic [AW-1:0]    diff;

    assign lsb = cmp_lsb(code_i, narrow_i);

    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign mask[i] = (LSB_W'(i) >= lsb);
    end

    assign diff    = (addr_i ^ open_page_i) & mask;
    assign match_o = ~|diff;

endmodule

// File: rtl/dpc_rfsh_timer.sv
module dpc_rfsh_timer #(
    parameter int PRESCALE = 16,
    parameter int RC_W     = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RC_W-1:0] count_i,
    output logic            pulse_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [RC_W-1:0]  rc_q;
    logic             tick;
    logic             wrap;

    assign tick    = (pre_q == PRE_W'(PRESCALE - 1));
    assign wrap    = (rc_q >= count_i);
    assign pulse_o = tick && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            rc_q  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                rc_q <= wrap ? '0 : rc_q + 1'b1;
            end
        end
    end

    AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R9

endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_i,
    input  logic              pgmode_i,
    input  logic              dlywr_i,
    input  logic              cfg_err_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              match_i,
    input  logic              rfsh_i,
    output logic [AW-1:0]     open_page_o,
    output logic              ras_o,
    output logic              cas_o,
    output logic              ack_o,
    output logic              hit_o
);
    seq_state_t        state_q;
    strobe_t           pins_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [AW-1:0]     page_q;
    logic              page_valid_q;
    logic              pend_q;
    logic              hit_q;
    logic              accept;
    logic              hit;
    logic              stretch;

    assign accept  = req_i && !pins_q.ack && !pend_q;
    assign hit     = page_valid_q && pgmode_i && match_i;
    assign stretch = wr_i && (dlywr_i || cfg_err_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pins_q       <= '0;
            cnt_q        <= '0;
            page_q       <= '0;
            page_valid_q <= 1'b0;
            pend_q       <= 1'b0;
            hit_q        <= 1'b0;
        end else begin
            pins_q.ack <= 1'b0;
            if (rfsh_i) begin
                pend_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        pins_q.ras   <= 1'b0;
                        pins_q.cas   <= 1'b0;
                        page_valid_q <= 1'b0;
                        state_q      <= ST_RF_PRE;
                    end else if (accept) begin
                        hit_q <= hit;
                        if (hit) begin
                            if (stretch) begin
                                state_q <= ST_CAS_GO;
                            end else begin
                                pins_q.cas <= 1'b1;
                                cnt_q      <= wait_i;
                                state_q    <= ST_CAS_ON;
                            end
                        end else begin
                            pins_q.ras   <= 1'b0;
                            page_valid_q <= 1'b0;
                            page_q       <= addr_i;
                            state_q      <= ST_PRECH;
                        end
                    end
                end
                ST_PRECH: begin
                    pins_q.ras   <= 1'b1;
                    page_valid_q <= pgmode_i;
                    state_q      <= ST_CAS_GO;
                end
                ST_CAS_GO: begin
                    pins_q.cas <= 1'b1;
                    cnt_q      <= wait_i;
                    state_q    <= ST_CAS_ON;
                end
                ST_CAS_ON: begin
                    if (cnt_q == '0) begin
                        pins_q.cas <= 1'b0;
                        pins_q.ack <= 1'b1;
                        if (!page_valid_q) begin
                            pins_q.ras <= 1'b0;
                        end
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RF_PRE: begin
                    pins_q.cas <= 1'b1;
                    state_q    <= ST_RF_CAS;
                end
                ST_RF_CAS: begin
                    pins_q.ras <= 1'b1;
                    state_q    <= ST_RF_RAS;
                end
                ST_RF_RAS: begin
                    pins_q.ras <= 1'b0;
                    pins_q.cas <= 1'b0;
                    if (!rfsh_i) begin
                        pend_q <= 1'b0;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign open_page_o = page_q;
    assign ras_o       = pins_q.ras;
    assign cas_o       = pins_q.cas;
    assign ack_o       = pins_q.ack;
    assign hit_o       = pins_q.ack && hit_q;

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pins_q.ack |=> !pins_q.ack); // R4
    AST_HIT_ROW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && accept && hit) |-> pins_q.ras); // R5
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAS_ON) |-> pins_q.ras); // R5
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins_q.ras) && state_q != ST_RF_RAS) |-> !pins_q.cas); // R5
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins_q.ras) && state_q == ST_RF_RAS) |-> pins_q.cas); // R10
    AST_FORCED_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && accept && hit && wr_i && cfg_err_i) |=> (state_q == ST_CAS_GO)); // R7

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int WAIT_W   = 4,
    parameter int RC_W     = 8,
    parameter int PRESCALE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_i,
    input  logic              port16_i,
    input  logic [2:0]        pgsz_i,
    input  logic              pgmode_i,
    input  logic              dlywr_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic [RC_W-1:0]   rfcnt_i,
    output logic              ras_o,
    output logic              cas_o,
    output logic              ack_o,
    output logic              hit_o,
    output logic              cfg_err_o
);
    logic [AW-1:0] open_page;
    logic          match;
    logic          rfsh;

    assign cfg_err_o = cfg_conflict(pgmode_i, dlywr_i, wait_i == '0);

    dpc_page_match #(.AW(AW)) u_match (
        .addr_i      (addr_i),
        .open_page_i (open_page),
        .code_i      (pgsz_i),
        .narrow_i    (port16_i),
        .match_o     (match)
    );

    dpc_rfsh_timer #(.PRESCALE(PRESCALE), .RC_W(RC_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .count_i (rfcnt_i),
        .pulse_o (rfsh)
    );

    dpc_seq #(.AW(AW), .WAIT_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .addr_i      (addr_i),
        .wr_i        (wr_i),
        .pgmode_i    (pgmode_i),
        .dlywr_i     (dlywr_i),
        .cfg_err_i   (cfg_err_o),
        .wait_i      (wait_i),
        .match_i     (match),
        .rfsh_i      (rfsh),
        .open_page_o (open_page),
        .ras_o       (ras_o),
        .cas_o       (cas_o),
        .ack_o       (ack_o),
        .hit_o       (hit_o)
    );

endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [25:0] addr = '0;
    logic        wr = 1'b0;
    logic        port16 = 1'b0;
    logic [2:0]  pgsz = '0;
    logic        pgmode = 1'b1;
    logic        dlywr = 1'b0;
    logic [3:0]  waitc = 4'd2;
    logic [7:0]  rfcnt = 8'd255;
    logic        ras, cas, ack, hit, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_page_ctrl u_dram_page_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .wr_i(wr),
        .port16_i(port16), .pgsz_i(pgsz), .pgmode_i(pgmode), .dlywr_i(dlywr),
        .wait_i(waitc), .rfcnt_i(rfcnt), .ras_o(ras), .cas_o(cas),
        .ack_o(ack), .hit_o(hit), .cfg_err_o(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pm, input logic dw, input logic [3:0] w, input logic [7:0] rc);
        pgmode = pm; dlywr = dw; waitc = w; rfcnt = rc;
        req = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic do_access(input logic [25:0] a, input logic w, output int lat, output int cfirst,
                             output int clen, output logic h, output logic ras1, output logic ras2,
                             output logic ras_after);
        int n = 0;
        lat = -1; cfirst = -1; clen = 0; h = 0; ras1 = 0; ras2 = 0;
        addr = a; wr = w; req = 1;
        while (lat < 0 && n < 60) begin
            @(negedge clk);
            n++;
            if (n == 1) ras1 = ras;
            if (n == 2) ras2 = ras;
            if (cas) begin
                if (cfirst < 0) cfirst = n;
                clen++;
            end
            if (ack) begin
                lat = n;
                h = hit;
                req = 0;
            end
        end
        @(negedge clk);
        ras_after = ras;
    endtask

    task automatic wait_cbr(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(cas && !ras) && n < 5000);
    endtask

    task automatic t_reset();
        int l, cf, cl; logic h, r1, r2, ra;
        do_reset(1, 0, 4'd2, 8'd255);
        chk(ras == 0 && cas == 0 && ack == 0, "R1", "strobes idle after reset", {ras, cas, ack}, 0);
        do_access(26'h0001234, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 0, "R1", "first access hit flag", h, 0);
    endtask

    task automatic t_mask(input logic narrow);
        int l, cf, cl; logic h, r1, r2, ra;
        logic [25:0] base;
        string tag;
        base = 26'h2B5C3A7;
        tag = narrow ? "R3" : "R2";
        do_reset(1, 0, 4'd1, 8'd255);
        port16 = narrow;
        for (int c = 0; c < 8; c++) begin
            int lo;
            pgsz = 3'(c);
            lo = 10 + (c + 1) / 2 - (narrow ? 1 : 0);
            do_access(base, 0, l, cf, cl, h, r1, r2, ra);
            do_access(base ^ (26'd1 << (lo - 1)) ^ 26'd1, 0, l, cf, cl, h, r1, r2, ra);
            chk(h == 1, tag, $sformatf("code %0d bit below boundary hit", c), h, 1);
            do_access(base ^ (26'd1 << lo), 0, l, cf, cl, h, r1, r2, ra);
            chk(h == 0, tag, $sformatf("code %0d boundary bit miss", c), h, 0);
        end
        do_access(base, 0, l, cf, cl, h, r1, r2, ra);
        do_access(base ^ 26'h2000000, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 0, tag, "top bit compared", h, 0);
        port16 = 0;
    endtask

    task automatic t_timing();
        int l, cf, cl; logic h, r1, r2, ra;
        do_reset(1, 0, 4'd2, 8'd255);
        pgsz = 3'd3;
        do_access(26'h0100000, 0, l, cf, cl, h, r1, r2, ra);
        chk(l == 6, "R5", "miss ack latency", l, 6);
        chk(cf == 3, "R5", "miss first CAS cycle", cf, 3);
        chk(r1 == 0 && r2 == 1, "R5", "precharge then row open", {r1, r2}, 1);
        do_access(26'h0100040, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 1, "R5", "new page kept open", h, 1);
        chk(l == 4, "R4", "hit read ack latency", l, 4);
        chk(cf == 1 && cl == 3, "R4", "hit read CAS start and width", cf * 10 + cl, 13);
        do_access(26'h0100080, 1, l, cf, cl, h, r1, r2, ra);
        chk(l == 4, "R6", "hit write without delay", l, 4);
        dlywr = 1;
        do_access(26'h0100044, 1, l, cf, cl, h, r1, r2, ra);
        chk(l == 5, "R6", "delayed hit write latency", l, 5);
        chk(cf == 2 && cl == 3, "R6", "delayed write CAS start and width", cf * 10 + cl, 23);
        do_access(26'h0100048, 0, l, cf, cl, h, r1, r2, ra);
        chk(l == 4, "R6", "hit read unaffected by delay", l, 4);
        do_access(26'h0300000, 1, l, cf, cl, h, r1, r2, ra);
        chk(l == 6, "R6", "miss write unaffected by delay", l, 6);
        chk(cfg_err == 0, "R7", "no conflict with wait 2", cfg_err, 0);
        dlywr = 0;
    endtask

    task automatic t_force();
        int l, cf, cl; logic h, r1, r2, ra;
        do_reset(1, 0, 4'd0, 8'd255);
        chk(cfg_err == 1, "R7", "conflict flagged", cfg_err, 1);
        do_access(26'h0040000, 0, l, cf, cl, h, r1, r2, ra);
        do_access(26'h0040004, 1, l, cf, cl, h, r1, r2, ra);
        chk(h == 1 && l == 3, "R7", "forced stretch hit write latency", l, 3);
        do_access(26'h0040008, 0, l, cf, cl, h, r1, r2, ra);
        chk(l == 2, "R7", "zero-wait hit read latency", l, 2);
        dlywr = 1;
        @(negedge clk);
        chk(cfg_err == 0, "R7", "no conflict with delay on", cfg_err, 0);
        pgmode = 0; dlywr = 0;
        @(negedge clk);
        chk(cfg_err == 0, "R7", "no conflict with page mode off", cfg_err, 0);
    endtask

    task automatic t_nopage();
        int l, cf, cl; logic h, r1, r2, ra;
        do_reset(0, 0, 4'd1, 8'd255);
        do_access(26'h0010000, 0, l, cf, cl, h, r1, r2, ra);
        chk(ra == 0, "R8", "RAS closed after access", ra, 0);
        do_access(26'h0010000, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 0 && l == 5, "R8", "repeat access still a miss", l, 5);
    endtask

    task automatic t_period();
        int n;
        do_reset(1, 0, 4'd1, 8'd3);
        wait_cbr(n);
        wait_cbr(n);
        chk(n == 64, "R9", "refresh period count 3", n, 64);
        rfcnt = 8'd1;
        wait_cbr(n);
        wait_cbr(n);
        chk(n == 32, "R9", "refresh period count 1", n, 32);
    endtask

    task automatic t_cbr();
        int l, cf, cl, n; logic h, r1, r2, ra;
        do_reset(1, 0, 4'd1, 8'd3);
        do_access(26'h0200000, 0, l, cf, cl, h, r1, r2, ra);
        do_access(26'h0200010, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 1, "R10", "page open before refresh", h, 1);
        wait_cbr(n);
        chk(cas == 1 && ras == 0, "R10", "CAS before RAS", {cas, ras}, 2);
        @(negedge clk);
        chk(cas == 1 && ras == 1, "R10", "RAS joins CAS", {cas, ras}, 3);
        @(negedge clk);
        chk(cas == 0 && ras == 0, "R10", "both released", {cas, ras}, 0);
        do_access(26'h0200010, 0, l, cf, cl, h, r1, r2, ra);
        chk(h == 0, "R10", "access after refresh is a miss", h, 0);
    endtask

    task automatic t_priority();
        int n, cbr_at, ack_at;
        do_reset(1, 0, 4'd1, 8'd3);
        wait_cbr(n);
        repeat (62) @(negedge clk);
        addr = 26'h0050000; wr = 0; req = 1;
        cbr_at = -1; ack_at = -1; n = 0;
        while (ack_at < 0 && n < 60) begin
            @(negedge clk);
            n++;
            if (cas && !ras && cbr_at < 0) cbr_at = n;
            if (ack) begin ack_at = n; req = 0; end
        end
        chk(cbr_at > 0 && cbr_at < ack_at, "R11", "refresh before waiting request", cbr_at, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mask(0);
        t_mask(1);
        t_timing();
        t_force();
        t_nopage();
        t_period();
        t_cbr();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule